// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Transceiver

This block is a serial master that moves one byte out and one byte in at the same time over a serial clock, a data-out line and a data-in line. The host reaches it through a small register bus. Writing a byte into the transmit holding register starts a combined transfer. The byte is copied into a shift register, and the holding register becomes free again while the bits shift. The host can therefore queue the next byte and get back-to-back frames.

Each received byte lands in a receive holding register and raises a receive-full flag. The 0-to-1 edge of that flag produces a one-cycle interrupt pulse. If a frame completes while the previous byte has not yet been read, the new byte is discarded and an overrun flag latches. All traffic then stops until software clears the flag. A transmit-end flag reports that the last queued byte has fully left the shift register. Separate enables gate the transmit side and the receive side. The bit rate comes from a programmable divider of the system clock.

Register map (2-bit address, DW-bit data):
- Address 0: write loads transmit data; read returns receive data.
- Address 1: status. Bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is overrun and bit 3 is transmit-end. Writing 1 to bit 2 or bit 3 clears that flag.
- Address 2: control. Bit 0 is transmit enable and bit 1 is receive enable.
- Address 3: half-period divider value D.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, status reads 0x09 (transmit-empty and transmit-end set, all other flags clear), control reads 0 and the serial clock is low.
- R2: A write to address 0 while transmit-empty is 1 stores the byte and clears transmit-empty. If transmit enable is set and overrun is clear, a frame begins and transmit-end clears.
- R3: When the held byte moves into the shift register at frame start, transmit-empty returns to 1. A second byte written during the frame is sent in the next frame without any further host action.
- R4: A frame is 8 serial clock pulses, MSB first. The serial clock idles low. Data-out changes on the falling edge and data-in is sampled on the rising edge. Each clock half period lasts D+1 system clocks.
- R5: When a frame ends with receive enable set and receive-full clear, the received byte becomes readable at address 0 and receive-full sets. A read of address 0 clears receive-full.
- R6: The receive interrupt output is a single-cycle pulse on each 0-to-1 transition of receive-full.
- R7: A frame that ends while receive-full is 1 (receive enabled) sets overrun and keeps the old received byte. While overrun is 1, no frame starts. Writing 1 to status bit 2 clears it, and a pending byte is then sent.
- R8: Transmit-end sets when a frame ends with no byte pending. Writing 1 to status bit 3 clears it.
- R9: A write to address 0 while transmit-empty is 0 is ignored, and the pending byte is sent unchanged.
- R10: With transmit enable clear, no frame starts and the serial clock stays low. With receive enable clear, a frame still runs but leaves receive-full and the receive interrupt untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only at address 0) |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the addressed register |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench loops data-out back to data-in, optionally inverted, so that every received byte is known. It checks the following corner cases:
- Queuing a second byte mid-frame: a design that ran the frames back to back wrongly would drop that byte.
- A third write while a byte is still pending: a design that did not ignore it would corrupt the pending byte.
- Two frames completing with no read in between: the bench checks that the first byte survives, that nothing moves while overrun is set, and that clearing overrun releases the queued byte. A design without the freeze would keep toggling the serial clock.
- Disabled transmit and disabled receive: a wrong design would start frames with the enable off, or set receive-full with the receive side off.

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi,
  output logic          rx_irq
);
  localparam int BCW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0]  txbuf, txsh, rxsh, rxbuf, div, cnt;
  logic [BCW-1:0] bitn;
  logic tx_empty, rx_full, ovr, tx_end, tx_en, rx_en, busy, sclk_q, rx_full_q;

  wire wr_tx = wr_en && addr == 2'd0 && tx_empty;
  wire rd_rx = rd_en && addr == 2'd0;
  wire wr_st = wr_en && addr == 2'd1;
  wire start = !busy && !tx_empty && tx_en && !ovr;
  wire tick  = busy && cnt == div;
  wire rise  = tick && !sclk_q;
  wire fall  = tick && sclk_q;
  wire done  = fall && bitn == BCW'(DW - 1);

  assign sclk   = sclk_q;
  assign sdo    = txsh[DW-1];
  assign rx_irq = rx_full && !rx_full_q;

  always_comb begin
    case (addr)
      2'd0:    rdata = rxbuf;
      2'd1:    rdata = DW'({tx_end, ovr, rx_full, tx_empty});
      2'd2:    rdata = DW'({rx_en, tx_en});
      default: rdata = div;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf <= '0; txsh <= '0; rxsh <= '0; rxbuf <= '0; div <= '0; cnt <= '0;
      bitn <= '0; busy <= 1'b0; sclk_q <= 1'b0; rx_full_q <= 1'b0;
      tx_empty <= 1'b1; tx_end <= 1'b1; rx_full <= 1'b0; ovr <= 1'b0;
      tx_en <= 1'b0; rx_en <= 1'b0;
    end else begin
      rx_full_q <= rx_full;
      cnt <= (!busy || tick) ? '0 : cnt + 1'b1;

      if (wr_st && wdata[2]) ovr <= 1'b0;
      if (wr_st && wdata[3]) tx_end <= 1'b0;
      if (wr_en && addr == 2'd2) begin
        tx_en <= wdata[0];
        rx_en <= wdata[1];
      end
      if (wr_en && addr == 2'd3) div <= wdata;

      if (start) begin
        txsh     <= txbuf;
        tx_empty <= 1'b1;
        busy     <= 1'b1;
        tx_end   <= 1'b0;
        bitn     <= '0;
        sclk_q   <= 1'b0;
      end else if (wr_tx) begin
        txbuf    <= wdata;
        tx_empty <= 1'b0;
      end

      if (rise) begin
        sclk_q <= 1'b1;
        rxsh   <= {rxsh[DW-2:0], sdi};
      end
      if (fall) begin
        sclk_q <= 1'b0;
        txsh   <= {txsh[DW-2:0], 1'b0};
        bitn   <= bitn + 1'b1;
      end

      if (done) begin
        busy   <= 1'b0;
        tx_end <= tx_empty;
      end

      if (done && rx_en) begin
        if (rx_full && !rd_rx) ovr <= 1'b1;
        else begin
          rxbuf   <= rxsh;
          rx_full <= 1'b1;
        end
      end else if (rd_rx) rx_full <= 1'b0;
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  assert_freeze_on_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !busy) |=> !busy);
  assert_rx_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> $stable(rxbuf));
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  assert_empty_at_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_empty);
  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !tx_empty) |=> $stable(txbuf));
  assert_no_tx_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);
endmodule

// File: tb/sync_serial_xcvr_tb_top.sv
module sync_serial_xcvr_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, inv = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic sclk, sdo, sdi, rx_irq;
  int n_chk = 0, n_fail = 0, rises = 0, irqs = 0, hcnt = 0, hlen = 0;
  logic [7:0] cap = 0;

  always #10 clk = ~clk;
  assign sdi = sdo ^ inv;

  sync_serial_xcvr #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .sdo(sdo), .sdi(sdi), .rx_irq(rx_irq));

  always @(posedge sclk) begin
    cap <= {cap[6:0], sdo};
    rises <= rises + 1;
  end
  always @(posedge clk) begin
    if (rx_irq) irqs <= irqs + 1;
    if (sclk) hcnt <= hcnt + 1;
    else if (hcnt != 0) begin hlen <= hcnt; hcnt <= 0; end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wait_bit(int b, string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(2'd1, s);
      if (s[b]) return;
    end
    check(tag, 0, 1);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(2'd1, v); check("R1 status", v, 8'h09);
    bus_rd(2'd2, v); check("R1 control", v, 0);
    check("R1 sclk", sclk, 0);
  endtask

  task automatic t_tx_disabled;
    logic [7:0] v;
    bus_wr(2'd3, 8'd3);
    bus_wr(2'd0, 8'hA5);
    repeat (100) @(posedge clk);
    check("R10 no clock with transmit off", rises, 0);
    bus_rd(2'd1, v); check("R2 transmit-empty cleared", v[0], 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    bus_wr(2'd2, 8'h03);
    wait_bit(1, "R5 receive-full timeout");
    check("R4 pulse count", rises, 8);
    check("R4 bits MSB first", cap, 8'hA5);
    check("R4 half period", hlen, 4);
    check("R6 one irq", irqs, 1);
    bus_rd(2'd1, v); check("R8 transmit-end set", v[3], 1);
    bus_rd(2'd0, v); check("R5 data", v, 8'hA5);
    bus_rd(2'd1, v); check("R5 receive-full cleared", v[1], 0);
  endtask

  task automatic t_chain;
    logic [7:0] v;
    inv = 1;
    bus_wr(2'd0, 8'h3C);
    repeat (3) @(posedge clk);
    bus_rd(2'd1, v); check("R3 empty after load", v[0], 1);
    check("R2 transmit-end cleared", v[3], 0);
    bus_wr(2'd0, 8'h81);
    bus_wr(2'd0, 8'hFF);
    wait_bit(1, "R5 first frame timeout");
    bus_rd(2'd0, v); check("R5 inverted data", v, 8'hC3);
    wait_bit(1, "R3 second frame timeout");
    bus_rd(2'd0, v); check("R9 pending byte intact", v, 8'h7E);
    check("R6 irq per frame", irqs, 3);
    inv = 0;
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    int r0;
    bus_wr(2'd0, 8'h11);
    wait_bit(0, "R3 empty timeout");
    bus_wr(2'd0, 8'h22);
    wait_bit(2, "R7 overrun timeout");
    bus_wr(2'd0, 8'h33);
    r0 = rises;
    repeat (150) @(posedge clk);
    check("R7 frozen", rises, r0);
    bus_rd(2'd0, v); check("R7 old byte kept", v, 8'h11);
    bus_wr(2'd1, 8'h04);
    bus_rd(2'd1, v); check("R7 overrun cleared", v[2], 0);
    wait_bit(1, "R7 resume timeout");
    bus_rd(2'd0, v); check("R7 resumed data", v, 8'h33);
  endtask

  task automatic t_end_clear;
    logic [7:0] v;
    wait_bit(3, "R8 transmit-end timeout");
    bus_wr(2'd1, 8'h08);
    bus_rd(2'd1, v); check("R8 transmit-end cleared", v[3], 0);
  endtask

  task automatic t_rx_off;
    logic [7:0] v;
    int i0;
    i0 = irqs;
    bus_wr(2'd2, 8'h01);
    bus_wr(2'd0, 8'h55);
    wait_bit(3, "R10 frame timeout");
    check("R4 bits with receive off", cap, 8'h55);
    bus_rd(2'd1, v); check("R10 receive-full untouched", v[1], 0);
    check("R10 no irq", irqs, i0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_tx_disabled;
    t_basic;
    t_chain;
    t_overrun;
    t_end_clear;
    t_rx_off;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule